// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer that counts ticks from a slow enable (nominally 128 kHz) and, when it reaches its limit, either raises an interrupt request or requests a system reset. The limit is 2048 ticks scaled up by a power of two chosen through a 4-bit prescale field. Software keeps the watchdog quiet by pulsing the kick input, which stands for the restart instruction of the processor.

The configuration sits behind a guard. The prescale field and a clear of the reset-enable bit are accepted only during a short unlock period. An unlock write opens that period, and it lasts four system clock cycles. Outside the unlock period, software can still arm reset-enable, change the interrupt enable and clear the reset flag. A flag records that a watchdog reset was requested. While that flag is set, reset-enable cannot be turned off.

Top module: `wdt_guard`

## Requirements
- R1: The control register holds the prescale in bits [3:0], interrupt enable in bit 4, reset enable in bit 5, the unlock indication in bit 6 (it reads 1 while writes are unlocked) and the reset flag in bit 7. After reset it reads 0x00.
- R2: A write with bits 6 and 5 both 1, made while writes are locked, is the unlock write. It changes nothing else, and it unlocks writes at the next four clock edges only.
- R3: A write made while unlocked loads prescale, interrupt enable and reset enable from the data, and it restarts the count.
- R4: A write made while locked leaves the prescale unchanged. It can set reset enable but never clear it, and it loads interrupt enable from the data.
- R5: Any write other than the unlock write clears the reset flag when data bit 7 is 0; writing 1 to bit 7 has no effect. If the flag was set before a write, reset enable stays 1 after that write, even while unlocked.
- R6: The timeout falls on the (2048 << prescale)-th tick after the count restarts. With interrupt enable set, irq_o pulses for one cycle after the clock edge that takes that tick, and the count restarts.
- R7: On timeout with interrupt enable clear and reset enable set, the reset flag is set and rst_req_o pulses for exactly one cycle. It is never high together with irq_o.
- R8: A kick restarts the count when either enable is set.
- R9: With both enables clear the count is held and no timeout occurs, whatever the ticks and kicks.
- R10: A write that changes the prescale or either enable restarts the count. A locked write that changes none of them leaves the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| kick_i | input | 1 | Watchdog restart pulse |
| tick_i | input | 1 | Slow time base enable, one clock wide |
| ctrl_o | output | 8 | Control register readback |
| irq_o | output | 1 | Timeout interrupt request pulse |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The hardest state to reach from the ports is a set reset flag combined with an unlocked write that tries to clear reset enable. Getting there takes a full reset-mode timeout of 2048 ticks, followed by an unlock write and then unlocked writes that clear the flag. The stimulus holds the tick high every cycle to cover the timeout, stops the tick once the flag is set, and then clears the flag in an unlocked write. That write must still leave reset enable at 1, which shows the forced value comes from the flag as it stood before the write. A second unlocked write then clears reset enable. The edges of the unlock period are found by writing at the fourth and at the fifth clock edge after the unlock write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PSEL_W   = 4;
  localparam int BIT_IE   = 4;
  localparam int BIT_RE   = 5;
  localparam int BIT_UNLK = 6;
  localparam int BIT_FLAG = 7;

  typedef struct packed {
    logic              flag;
    logic              re;
    logic              ie;
    logic [PSEL_W-1:0] psel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_win.sv
module wdt_win #(
  parameter int WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  output logic win_open_o
);
  localparam int WC_W = $clog2(WIN_CYC + 1);

  logic [WC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (open_i)           cnt_q <= WC_W'(WIN_CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign win_open_o = (cnt_q != '0);

  AST_WIN_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> win_open_o); // R2
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WC_W'(WIN_CYC)); // R2
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic     win_open_i,
  input  logic     set_flag_i,
  output wdt_cfg_t cfg_o,
  output logic     open_req_o,
  output logic     restart_o
);
  wdt_cfg_t cfg_q, cfg_d;
  logic     wr_cfg;

  assign open_req_o = wr_en_i && !win_open_i && wr_data_i[BIT_UNLK] && wr_data_i[BIT_RE];
  assign wr_cfg     = wr_en_i && !open_req_o;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      if (win_open_i) begin
        cfg_d.psel = wr_data_i[PSEL_W-1:0];
        cfg_d.ie   = wr_data_i[BIT_IE];
        // flag as held before this write pins reset enable
        cfg_d.re   = wr_data_i[BIT_RE] | cfg_q.flag;
      end else begin
        cfg_d.ie   = wr_data_i[BIT_IE];
        cfg_d.re   = cfg_q.re | wr_data_i[BIT_RE];
      end
      if (!wr_data_i[BIT_FLAG]) cfg_d.flag = 1'b0;
    end
    if (set_flag_i) cfg_d.flag = 1'b1;
  end

  assign restart_o = wr_cfg && (win_open_i ||
                                (cfg_d.psel != cfg_q.psel) ||
                                (cfg_d.ie   != cfg_q.ie)   ||
                                (cfg_d.re   != cfg_q.re));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_OPEN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_req_o && !set_flag_i) |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              restart_i,
  input  logic              ie_i,
  input  logic              re_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              timeout_o
);
  localparam int CNT_W = BASE_LOG2 + (1 << PSEL_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             running, at_end, clear;

  assign running   = ie_i || re_i;
  assign limit     = CNT_W'(1) << (BASE_LOG2 + int'(psel_i));
  assign at_end    = (cnt_q == limit - 1'b1);
  assign clear     = restart_i || (kick_i && running);
  assign timeout_o = running && tick_i && at_end && !clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear || !running)  cnt_q <= '0;
    else if (tick_i)             cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit); // R6
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && running) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int WIN_CYC   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       kick_i,
  input  logic       tick_i,
  output logic [7:0] ctrl_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  wdt_cfg_t cfg;
  logic     win_open, open_req, restart, timeout, to_reset;
  logic     irq_q, rst_q;

  assign to_reset = timeout && !cfg.ie && cfg.re;

  wdt_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (open_req),
    .win_open_o (win_open)
  );

  wdt_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .win_open_i (win_open),
    .set_flag_i (to_reset),
    .cfg_o      (cfg),
    .open_req_o (open_req),
    .restart_o  (restart)
  );

  wdt_cnt #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .kick_i    (kick_i),
    .restart_i (restart),
    .ie_i      (cfg.ie),
    .re_i      (cfg.re),
    .psel_i    (cfg.psel),
    .timeout_o (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= timeout && cfg.ie;
      rst_q <= to_reset;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
  assign ctrl_o    = {cfg.flag, win_open, cfg.re, cfg.ie, cfg.psel};

  AST_PSEL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open |=> $stable(cfg.psel)); // R4
  AST_RE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_open && cfg.re) |=> cfg.re); // R4
  AST_FLAG_KEEPS_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.flag |-> cfg.re); // R5
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R7
  AST_IRQ_NOT_WITH_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg.ie || cfg.re) |=> (!irq_o && !rst_req_o)); // R9
endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       kick = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] ctrl;
  logic       irq, rst_req;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  wdt_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .kick_i(kick), .tick_i(tick), .ctrl_o(ctrl), .irq_o(irq), .rst_req_o(rst_req)
  );

  // {unlock first, data, expected readback}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b0, 8'h10, 8'h10},
    {1'b0, 8'h05, 8'h00},
    {1'b0, 8'h20, 8'h20},
    {1'b0, 8'h00, 8'h20},
    {1'b1, 8'h03, 8'h03},
    {1'b1, 8'h31, 8'h31},
    {1'b0, 8'h0F, 8'h21},
    {1'b1, 8'h00, 8'h00}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl, 8'h00, "R1 reset readback");
    chk({7'b0, irq | rst_req}, 8'h00, "R1 reset outputs");

    // table walk: locked and unlocked writes (R3 R4)
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][16]) wr(8'h60);
      wr(VEC[i][15:8]);
      run(5);
      chk(ctrl, VEC[i][7:0], VEC[i][16] ? "R3 unlocked write" : "R4 locked write");
    end

    // unlock period length (R2)
    wr(8'h60);
    chk(ctrl, 8'h40, "R2 unlock shown, nothing else changed");
    run(3);
    chk({7'b0, ctrl[6]}, 8'h01, "R2 still unlocked at 4th edge");
    step();
    chk({7'b0, ctrl[6]}, 8'h00, "R2 locked after 4 edges");
    wr(8'h60); run(3); wr(8'h07); run(5);
    chk(ctrl, 8'h07, "R2 write on 4th edge accepted");
    wr(8'h60); run(4); wr(8'h02); run(5);
    chk(ctrl, 8'h07, "R2 write on 5th edge locked");
    wr(8'h60); wr(8'h00); run(5);

    // interrupt timeout and periodic restart (R6)
    tick = 1'b1;
    wr(8'h60); wr(8'h10);
    run(2047);
    chk({7'b0, irq}, 8'h00, "R6 no irq before limit");
    step();
    chk({6'b0, irq, rst_req}, 8'h02, "R6 irq at 2048th tick");
    step();
    chk({7'b0, irq}, 8'h00, "R6 irq one cycle");
    run(2047);
    chk({7'b0, irq}, 8'h01, "R6 irq again after restart");

    // kick (R8)
    run(999); kick = 1'b1; step(); kick = 1'b0;
    run(1048);
    chk({7'b0, irq}, 8'h00, "R8 kick delayed timeout");
    run(1000);
    chk({7'b0, irq}, 8'h01, "R8 timeout 2048 after kick");

    // locked writes with and without change (R10)
    run(499); wr(8'h10); run(1548);
    chk({7'b0, irq}, 8'h01, "R10 unchanged write keeps count");
    run(499); wr(8'h30); run(1548);
    chk({7'b0, irq}, 8'h00, "R10 changing write restarts");
    run(500);
    chk({7'b0, irq}, 8'h01, "R10 timeout after restart");

    // reset request (R7)
    wr(8'h60); wr(8'h20);
    run(2047);
    chk({7'b0, rst_req}, 8'h00, "R7 no reset before limit");
    step();
    chk({6'b0, irq, rst_req}, 8'h01, "R7 reset request, no irq");
    chk(ctrl, 8'hA0, "R7 flag set");
    step();
    chk({7'b0, rst_req}, 8'h00, "R7 reset request one cycle");
    tick = 1'b0;

    // flag handling (R5)
    wr(8'h80); run(5);
    chk(ctrl, 8'hA0, "R5 locked write keeps flag and re");
    wr(8'h60); wr(8'h80); run(5);
    chk(ctrl, 8'hA0, "R5 unlocked write cannot clear re while flag set");
    wr(8'h60); wr(8'h00); run(5);
    chk(ctrl, 8'h20, "R5 flag cleared, re held by prior flag");
    wr(8'h60); wr(8'h00); run(5);
    chk(ctrl, 8'h00, "R5 re cleared once flag gone");

    // disabled (R9)
    tick = 1'b1;
    bad = 0;
    for (int i = 0; i < 2100; i++) begin
      kick = (i % 700 == 5);
      step();
      if (irq || rst_req) bad++;
    end
    kick = 1'b0;
    chk(8'(bad), 8'h00, "R9 no timeout when disabled");
    chk(ctrl, 8'h00, "R9 register unchanged");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule